// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves 8-bit words between two buses, called A and B. Each direction has its own capture register with its own clock. The register for the A-to-B direction samples the A input word. The register for the B-to-A direction samples the B input word. For each direction, a select input chooses what is sent to the far bus: the live word from the near bus, or the word held in that direction's register. This lets a stored word be replayed onto the far bus while new words keep being captured.

An active-low output enable permits driving at all. A direction input then picks which one bus is driven. Real tristate pins are not used. Each bus is modelled as an input word, an output word and a drive flag, and the surrounding pad logic turns the flag into a real output enable.

The two registers share one asynchronous active-low reset. Inside the block, the release of that reset is resynchronised separately to each capture clock. The multiplexers and drive flags are purely combinational.

Top module: `dual_reg_xcvr`

## Requirements
- R1: While `rst_n` is low, and until two rising edges of its own clock have followed the release of `rst_n`, each register holds zero and ignores its clock.
- R2: Once out of reset, the A-to-B register loads `a_in` on each rising edge of `clk_ab` and holds its value between those edges.
- R3: Once out of reset, the B-to-A register loads `b_in` on each rising edge of `clk_ba` and holds its value between those edges.
- R4: With `sel_ab_stored` = 0 and `b_drv` high, `b_out` equals `a_in` in the same cycle, with no clock edge needed.
- R5: With `sel_ab_stored` = 1 and `b_drv` high, `b_out` equals the A-to-B register contents, whatever `a_in` does.
- R6: With `b_drv` replaced by `a_drv`, `sel_ba_stored` chooses what `a_out` shows: 0 gives the live `b_in`, and 1 gives the B-to-A register contents.
- R7: With `oe_n` = 0, `dir_a2b` = 1 sets `b_drv` = 1 and `a_drv` = 0, and `dir_a2b` = 0 sets `a_drv` = 1 and `b_drv` = 0.
- R8: With `oe_n` = 1, both drive flags are 0, and both registers still capture on their clocks.
- R9: `a_drv` and `b_drv` are never 1 together.
- R10: An output word whose drive flag is 0 reads all zeros.
- R11: A capture edge on one register's clock leaves the other register unchanged. Both registers may capture on the same instant while a live transfer is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| oe_n | input | 1 | Active-low output enable |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab_stored | input | 1 | 1: B receives the stored A-to-B word; 0: B receives the live `a_in` |
| sel_ba_stored | input | 1 | 1: A receives the stored B-to-A word; 0: A receives the live `b_in` |
| a_in | input | 8 | Word currently present on bus A |
| a_out | output | 8 | Word offered to bus A; zero when not driven |
| a_drv | output | 1 | Drive flag for bus A |
| b_in | input | 8 | Word currently present on bus B |
| b_out | output | 8 | Word offered to bus B; zero when not driven |
| b_drv | output | 1 | Drive flag for bus B |

## Verification
Two functions can fall in the same cycle: a live transfer onto the driven bus, and a capture on one or both register clocks. The bench raises both clocks at the same instant while the live path is driving B. It then checks three things: the live output did not move across the edge, each register took the word on its own input, and a register whose clock stayed still kept its old word. The drive flags are also checked for every combination of `oe_n` and `dir_a2b`.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned XCVR_DW         = 8;
  localparam int unsigned XCVR_RST_STAGES = 2;

  typedef enum logic {
    XDIR_B_TO_A = 1'b0,
    XDIR_A_TO_B = 1'b1
  } xdir_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned DW         = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] near_in,
  input  logic          sel_stored,
  input  logic          drv,
  output logic [DW-1:0] far_out
);

  logic          lane_rst_n;
  logic [DW-1:0] held;
  logic [DW-1:0] picked;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (lane_rst_n)
  );

  xcvr_cap_reg #(.DW(DW)) i_cap_reg (
    .clk   (clk),
    .rst_n (lane_rst_n),
    .d     (near_in),
    .q     (held)
  );

  always_comb begin
    picked  = sel_stored ? held : near_in;
    far_out = drv ? picked : '0;
  end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir_a2b,
  output logic a_drv,
  output logic b_drv
);

  xdir_e dir;
  logic  enabled;

  always_comb begin
    dir     = xdir_e'(dir_a2b);
    enabled = !oe_n;
    a_drv   = enabled && (dir == XDIR_B_TO_A);
    b_drv   = enabled && (dir == XDIR_A_TO_B);
  end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned DW         = XCVR_DW,
  parameter int unsigned RST_STAGES = XCVR_RST_STAGES
) (
  input  logic          clk_ab,
  input  logic          clk_ba,
  input  logic          rst_n,
  input  logic          oe_n,
  input  logic          dir_a2b,
  input  logic          sel_ab_stored,
  input  logic          sel_ba_stored,
  input  logic [DW-1:0] a_in,
  output logic [DW-1:0] a_out,
  output logic          a_drv,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] b_out,
  output logic          b_drv
);

  localparam int unsigned NLANES = 2;

  logic              lane_clk [NLANES];
  logic [DW-1:0]     lane_in  [NLANES];
  logic              lane_sel [NLANES];
  logic              lane_drv [NLANES];
  logic [DW-1:0]     lane_out [NLANES];

  xcvr_drive_ctl i_drive_ctl (
    .oe_n    (oe_n),
    .dir_a2b (dir_a2b),
    .a_drv   (a_drv),
    .b_drv   (b_drv)
  );

  // lane 0: A side toward B, lane 1: B side toward A
  always_comb begin
    lane_clk[0] = clk_ab;
    lane_in[0]  = a_in;
    lane_sel[0] = sel_ab_stored;
    lane_drv[0] = b_drv;
    lane_clk[1] = clk_ba;
    lane_in[1]  = b_in;
    lane_sel[1] = sel_ba_stored;
    lane_drv[1] = a_drv;
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    xcvr_lane #(.DW(DW), .RST_STAGES(RST_STAGES)) i_lane (
      .clk        (lane_clk[g]),
      .rst_n      (rst_n),
      .near_in    (lane_in[g]),
      .sel_stored (lane_sel[g]),
      .drv        (lane_drv[g]),
      .far_out    (lane_out[g])
    );
  end

  assign b_out = lane_out[0];
  assign a_out = lane_out[1];

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_ab,
  input logic          clk_ba,
  input logic          rst_n,
  input logic          oe_n,
  input logic          dir_a2b,
  input logic          sel_ab_stored,
  input logic          sel_ba_stored,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] a_out,
  input logic          a_drv,
  input logic [DW-1:0] b_in,
  input logic [DW-1:0] b_out,
  input logic          b_drv
);

  p_one_driver_r9: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !(a_drv && b_drv));

  p_one_driver_ba_r9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !(a_drv && b_drv));

  p_iso_r8: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_drv && !b_drv));

  p_dir_a2b_r7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!oe_n && dir_a2b) |-> (b_drv && !a_drv));

  p_dir_b2a_r7: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!oe_n && !dir_a2b) |-> (a_drv && !b_drv));

  p_idle_zero_r10: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!b_drv |-> (b_out == '0)) and (!a_drv |-> (a_out == '0)));

  p_live_ab_r4: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_drv && !sel_ab_stored) |-> (b_out == a_in));

  p_live_ba_r6: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_drv && !sel_ba_stored) |-> (a_out == b_in));

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.DW(DW)) i_chk (
  .clk_ab        (clk_ab),
  .clk_ba        (clk_ba),
  .rst_n         (rst_n),
  .oe_n          (oe_n),
  .dir_a2b       (dir_a2b),
  .sel_ab_stored (sel_ab_stored),
  .sel_ba_stored (sel_ba_stored),
  .a_in          (a_in),
  .a_out         (a_out),
  .a_drv         (a_drv),
  .b_in          (b_in),
  .b_out         (b_out),
  .b_drv         (b_drv)
);

// File: tb/test_dual_reg_xcvr.sv
`timescale 1ns/1ps
module test_dual_reg_xcvr;

  localparam int DW = 8;

  logic          clk_ab = 1'b0;
  logic          clk_ba = 1'b0;
  logic          rst_n  = 1'b0;
  logic          oe_n   = 1'b1;
  logic          dir_a2b = 1'b1;
  logic          sel_ab_stored = 1'b0;
  logic          sel_ba_stored = 1'b0;
  logic [DW-1:0] a_in = '0;
  logic [DW-1:0] b_in = '0;
  logic [DW-1:0] a_out;
  logic [DW-1:0] b_out;
  logic          a_drv;
  logic          b_drv;

  int vectors = 0;
  int miscompares = 0;

  dual_reg_xcvr i_dual_reg_xcvr (
    .clk_ab        (clk_ab),
    .clk_ba        (clk_ba),
    .rst_n         (rst_n),
    .oe_n          (oe_n),
    .dir_a2b       (dir_a2b),
    .sel_ab_stored (sel_ab_stored),
    .sel_ba_stored (sel_ba_stored),
    .a_in          (a_in),
    .a_out         (a_out),
    .a_drv         (a_drv),
    .b_in          (b_in),
    .b_out         (b_out),
    .b_drv         (b_drv)
  );

  // 250 MHz: 2 ns high, 2 ns low per pulse
  task automatic pulse_ab();
    clk_ab = 1'b1; #2; clk_ab = 1'b0; #2;
  endtask

  task automatic pulse_ba();
    clk_ba = 1'b1; #2; clk_ba = 1'b0; #2;
  endtask

  task automatic pulse_both();
    clk_ab = 1'b1; clk_ba = 1'b1; #2;
    clk_ab = 1'b0; clk_ba = 1'b0; #2;
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    a_in = 8'hAA; b_in = 8'h55;
    pulse_both(); pulse_both();
    oe_n = 1'b0; dir_a2b = 1'b1; sel_ab_stored = 1'b1; settle();
    chk("R1 A-to-B reg zero in reset", b_out, 8'h00);
    dir_a2b = 1'b0; sel_ba_stored = 1'b1; settle();
    chk("R1 B-to-A reg zero in reset", a_out, 8'h00);
    rst_n = 1'b1;
    pulse_both(); pulse_both();
    settle();
    chk("R1 B-to-A reg zero during sync release", a_out, 8'h00);
    dir_a2b = 1'b1; settle();
    chk("R1 A-to-B reg zero during sync release", b_out, 8'h00);
  endtask

  task automatic t_drive_flags();
    for (int m = 0; m < 4; m++) begin
      oe_n = m[1]; dir_a2b = m[0]; settle();
      chk("R9 never both driven", {7'd0, a_drv & b_drv}, 8'h00);
      chk("R7 b_drv", {7'd0, b_drv}, {7'd0, !m[1] && m[0]});
      chk("R7 a_drv", {7'd0, a_drv}, {7'd0, !m[1] && !m[0]});
    end
  endtask

  task automatic t_realtime();
    oe_n = 1'b0; dir_a2b = 1'b1; sel_ab_stored = 1'b0;
    for (int i = 0; i < 4; i++) begin
      a_in = 8'h11 * (i + 3); b_in = 8'hE7; settle();
      chk("R4 live A onto B", b_out, 8'h11 * (i + 3));
      chk("R10 undriven A reads zero", a_out, 8'h00);
    end
    dir_a2b = 1'b0; sel_ba_stored = 1'b0;
    for (int i = 0; i < 3; i++) begin
      b_in = 8'h0F << i; settle();
      chk("R6 live B onto A", a_out, 8'h0F << i);
      chk("R10 undriven B reads zero", b_out, 8'h00);
    end
  endtask

  task automatic t_stored();
    oe_n = 1'b0; dir_a2b = 1'b1; sel_ab_stored = 1'b1;
    a_in = 8'h5A; pulse_ab();
    a_in = 8'hFF; settle();
    chk("R5 stored A shown on B", b_out, 8'h5A);
    chk("R2 holds between edges", b_out, 8'h5A);
    b_in = 8'h33; pulse_ba(); settle();
    chk("R11 clk_ba leaves A-to-B reg alone", b_out, 8'h5A);
    dir_a2b = 1'b0; sel_ba_stored = 1'b1; b_in = 8'hC0; settle();
    chk("R6 stored B shown on A", a_out, 8'h33);
    a_in = 8'h71; pulse_ab(); settle();
    chk("R11 clk_ab leaves B-to-A reg alone", a_out, 8'h33);
  endtask

  task automatic t_isolation();
    oe_n = 1'b1; sel_ab_stored = 1'b1; sel_ba_stored = 1'b1;
    a_in = 8'hC3; b_in = 8'h3C; settle();
    chk("R8 A not driven", {7'd0, a_drv}, 8'h00);
    chk("R8 B not driven", {7'd0, b_drv}, 8'h00);
    chk("R10 A word zero when isolated", a_out, 8'h00);
    chk("R10 B word zero when isolated", b_out, 8'h00);
    pulse_ab(); pulse_ba();
    a_in = 8'h00; b_in = 8'h00;
    oe_n = 1'b0; dir_a2b = 1'b1; settle();
    chk("R8 R2 capture from A while isolated", b_out, 8'hC3);
    dir_a2b = 1'b0; settle();
    chk("R8 R3 capture from B while isolated", a_out, 8'h3C);
  endtask

  task automatic t_rx_capture();
    oe_n = 1'b0; dir_a2b = 1'b1; sel_ab_stored = 1'b0; sel_ba_stored = 1'b1;
    a_in = 8'h96; b_in = 8'h96; settle();
    chk("R4 live before edge", b_out, 8'h96);
    clk_ab = 1'b1; clk_ba = 1'b1; #1;
    chk("R11 live output steady at edge", b_out, 8'h96);
    #1; clk_ab = 1'b0; clk_ba = 1'b0; #2;
    a_in = 8'h01; b_in = 8'h02;
    sel_ab_stored = 1'b1; settle();
    chk("R2 A reg captured while transmitting", b_out, 8'h96);
    dir_a2b = 1'b0; settle();
    chk("R3 receiving side captured into B reg", a_out, 8'h96);
    b_in = 8'h4D; pulse_ba(); settle();
    chk("R3 B reg follows next clk_ba edge", a_out, 8'h4D);
    dir_a2b = 1'b1; settle();
    chk("R11 A reg kept over clk_ba", b_out, 8'h96);
  endtask

  initial begin : watchdog
    #100000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_drive_flags();
    t_realtime();
    t_stored();
    t_isolation();
    t_rx_capture();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule